// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a byte-wide serial peripheral interface master that a processor drives through three consecutive byte registers on a simple single-cycle bus. Offset 0 is control, offset 1 is status and offset 2 is data. Writing the data register while the block is enabled starts one full-duplex transfer of eight bits. The controller drives the serial clock, shifts the byte out on the output line most significant bit first, and assembles the byte arriving on the input line. When the transfer ends, the received byte is held for the processor to read.

The serial clock is the system clock divided by 2, 4, 16 or 32, and all four combinations of idle polarity and capture phase are available. Completion raises a status flag and, when enabled, an interrupt. A data write that arrives while a byte is still moving is refused and recorded as a write collision. Flags are cleared by a two-step sequence: a status read records which flags are set, and the next data-register access, whether read or write, clears exactly the recorded ones.

The transfer engine is a three-state machine. XS_IDLE waits for an accepted data write and takes the transition *start* into XS_SHIFT. XS_SHIFT counts sixteen serial-clock edges; the transition *last edge* leads to XS_DONE. XS_DONE lasts one cycle, in which the received byte is committed and the completion flag is raised. It then takes *retire* back to XS_IDLE. A reset from any state returns to XS_IDLE.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, the data register reads 0x00, `spi_sck` is 0 and `irq` is 0.
- R2: Control (offset 0) holds bit 7 interrupt enable, bit 6 block enable, bit 5 and bit 4 as stored option bits with no effect, bit 3 clock idle level, bit 2 capture phase, and bits 1:0 rate code. It reads back as written. Offset 3 reads 0x00.
- R3: Rate code 0, 1, 2 or 3 gives a serial-clock half period of 1, 2, 8 or 16 system clock cycles, which divides the system clock by 2, 4, 16 or 32.
- R4: A transfer moves eight bits most significant bit first in both directions. Once the transfer has completed, a read of offset 2 returns the byte received on `spi_miso`.
- R5: While idle, `spi_sck` rests at the idle level (control bit 3). With capture phase 0, the first data bit is on `spi_mosi` before the first clock edge, each bit is captured on the first edge of its bit time, and data changes on the second edge. With capture phase 1, data changes on the first edge and is captured on the second.
- R6: A data write while control bit 6 is 0 is ignored. No clock edge is produced and status and data are unchanged.
- R7: A data write during a transfer does not change the outgoing byte and does not restart the transfer. It sets the write-collision flag (status bit 6).
- R8: The completion flag (status bit 7) is set after the sixteenth serial-clock edge. `irq` is 1 exactly while the completion flag and control bit 7 are both 1.
- R9: A status read records which flags are set. The next read or write of offset 2 clears only the recorded flags. A data access with nothing recorded clears nothing.
- R10: Writes to status have no effect. Status bits 5, 4 (mode fault, never set here) and 3:0 read 0.
- R11: The completion of a transfer discards any recording made before it, so that recording clears neither flag.
- R12: Reset during a transfer aborts it. `spi_sck` returns to 0 and no completion flag appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| spi_miso | input | 1 | Serial data in |
| spi_mosi | output | 1 | Serial data out |
| spi_sck | output | 1 | Serial clock |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that each bus strobe is one cycle wide and addresses a single register. They also assume the idle-level bit is not rewritten while a transfer runs, since the clock output follows that bit directly. The stimulus keeps within these limits: every access is a one-cycle strobe launched on the falling clock edge, and control is written only while the engine is idle. The one exception is the reset-abort case, where reset itself ends the transfer.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] OFS_CTRL = 2'd0;
    localparam logic [REG_ADDR_W-1:0] OFS_STAT = 2'd1;
    localparam logic [REG_ADDR_W-1:0] OFS_DATA = 2'd2;

    // control bit positions
    localparam int CB_IEN = 7;
    localparam int CB_EN  = 6;
    localparam int CB_POL = 3;
    localparam int CB_PHA = 2;
    localparam int CB_RT1 = 1;
    localparam int CB_RT0 = 0;

    // status bit positions
    localparam int SB_DONE = 7;
    localparam int SB_WCOL = 6;
    localparam int SB_MODF = 4;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_SHIFT = 2'd1,
        XS_DONE  = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/spi_reg_rate.sv
module spi_reg_rate #(
    parameter int CNT_W = 5,
    parameter int HALF0 = 1,
    parameter int HALF1 = 2,
    parameter int HALF2 = 8,
    parameter int HALF3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] rate,
    input  logic       run,
    output logic       tick
);

    logic [1:0]       rate_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    // rate is frozen at transfer start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q <= 2'd0;
        end else if (start) begin
            rate_q <= rate;
        end
    end

    always_comb begin
        unique case (rate_q)
            2'd0:    half_m1 = CNT_W'(HALF0 - 1);
            2'd1:    half_m1 = CNT_W'(HALF1 - 1);
            2'd2:    half_m1 = CNT_W'(HALF2 - 1);
            default: half_m1 = CNT_W'(HALF3 - 1);
        endcase
    end

    assign tick = run && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
    import spi_reg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] load_data,
    input  logic              cpha,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              finish,
    output logic              shifting,
    output logic              mosi,
    output logic              phase,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int EDGES = 2 * DATA_W;
    localparam int EC_W  = $clog2(EDGES);
    localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(EDGES - 1);

    xfer_state_t state_q, state_d;

    logic [EC_W-1:0]   edge_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              pha_q;
    logic              mosi_q;
    logic              phase_q;
    logic              first_half;

    // edge number edge_q+1 is odd: first edge of a bit
    assign first_half = ~edge_q[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:  if (start) state_d = XS_SHIFT;
            XS_SHIFT: if (tick && edge_q == LAST_EDGE) state_d = XS_DONE;
            XS_DONE:  state_d = XS_IDLE;
            default:  state_d = XS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        finish   = 1'b0;
        shifting = 1'b0;
        unique case (state_q)
            XS_IDLE:  ;
            XS_SHIFT: begin busy = 1'b1; shifting = 1'b1; end
            XS_DONE:  begin busy = 1'b1; finish = 1'b1; end
            default:  ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q  <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            pha_q   <= 1'b0;
            mosi_q  <= 1'b0;
            phase_q <= 1'b0;
            rx_byte <= '0;
        end else begin
            unique case (state_q)
                XS_IDLE: begin
                    if (start) begin
                        tx_q    <= load_data;
                        rx_q    <= '0;
                        edge_q  <= '0;
                        phase_q <= 1'b0;
                        pha_q   <= cpha;
                        if (!cpha) begin
                            mosi_q <= load_data[DATA_W-1];
                        end
                    end
                end
                XS_SHIFT: begin
                    if (tick) begin
                        phase_q <= ~phase_q;
                        edge_q  <= edge_q + 1'b1;
                        if (!pha_q) begin
                            if (first_half) begin
                                rx_q <= {rx_q[DATA_W-2:0], miso};
                            end else if (edge_q != LAST_EDGE) begin
                                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                                mosi_q <= tx_q[DATA_W-2];
                            end
                        end else begin
                            if (first_half) begin
                                mosi_q <= tx_q[DATA_W-1];
                                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                            end else begin
                                rx_q <= {rx_q[DATA_W-2:0], miso};
                            end
                        end
                    end
                end
                XS_DONE: begin
                    rx_byte <= rx_q;
                end
                default: ;
            endcase
        end
    end

    assign mosi  = mosi_q;
    assign phase = phase_q;

endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_reg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic                  busy,
    input  logic                  finish,
    input  logic [DATA_W-1:0]     rx_byte,
    output logic                  start,
    output logic                  en,
    output logic                  cpol,
    output logic                  cpha,
    output logic [1:0]            rate,
    output logic                  done_flag,
    output logic                  wcol_flag,
    output logic                  irq
);

    logic [DATA_W-1:0] ctrl_q;
    logic              done_q, wcol_q;
    logic              cap_done_q, cap_wcol_q;
    logic              ctrl_wr, stat_rd, data_rd, data_wr, data_ok, clr_evt;
    logic [DATA_W-1:0] stat_word;

    assign ctrl_wr = sel && wr  && (addr == OFS_CTRL);
    assign stat_rd = sel && !wr && (addr == OFS_STAT);
    assign data_rd = sel && !wr && (addr == OFS_DATA);
    assign data_wr = sel && wr  && (addr == OFS_DATA);
    assign data_ok = data_wr && ctrl_q[CB_EN];
    assign clr_evt = data_rd || data_ok;
    assign start   = data_ok && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata;
        end
    end

    // flags and the status-read recording
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            wcol_q     <= 1'b0;
            cap_done_q <= 1'b0;
            cap_wcol_q <= 1'b0;
        end else begin
            if (clr_evt && cap_done_q) done_q <= 1'b0;
            if (finish)                done_q <= 1'b1;
            if (clr_evt && cap_wcol_q) wcol_q <= 1'b0;
            if (data_ok && busy)       wcol_q <= 1'b1;
            if (stat_rd) begin
                cap_done_q <= done_q;
                cap_wcol_q <= wcol_q;
            end else if (clr_evt || finish) begin
                cap_done_q <= 1'b0;
                cap_wcol_q <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_word          = '0;
        stat_word[SB_DONE] = done_q;
        stat_word[SB_WCOL] = wcol_q;
        stat_word[SB_MODF] = 1'b0;
    end

    always_comb begin
        unique case (addr)
            OFS_CTRL: rdata = ctrl_q;
            OFS_STAT: rdata = stat_word;
            OFS_DATA: rdata = rx_byte;
            default:  rdata = '0;
        endcase
    end

    assign en        = ctrl_q[CB_EN];
    assign cpol      = ctrl_q[CB_POL];
    assign cpha      = ctrl_q[CB_PHA];
    assign rate      = {ctrl_q[CB_RT1], ctrl_q[CB_RT0]};
    assign done_flag = done_q;
    assign wcol_flag = wcol_q;
    assign irq       = done_q && ctrl_q[CB_IEN];

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
    import spi_reg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  spi_miso,
    output logic                  spi_mosi,
    output logic                  spi_sck,
    output logic                  irq
);

    logic              start, busy, finish, shifting, tick, phase;
    logic              en, cpol, cpha, done_flag, wcol_flag;
    logic [1:0]        rate;
    logic [DATA_W-1:0] rx_byte;

    spi_reg_file #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (bus_sel),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .busy      (busy),
        .finish    (finish),
        .rx_byte   (rx_byte),
        .start     (start),
        .en        (en),
        .cpol      (cpol),
        .cpha      (cpha),
        .rate      (rate),
        .done_flag (done_flag),
        .wcol_flag (wcol_flag),
        .irq       (irq)
    );

    spi_reg_rate #(.CNT_W(CNT_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .rate  (rate),
        .run   (shifting),
        .tick  (tick)
    );

    spi_reg_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_data (bus_wdata),
        .cpha      (cpha),
        .tick      (tick),
        .miso      (spi_miso),
        .busy      (busy),
        .finish    (finish),
        .shifting  (shifting),
        .mosi      (spi_mosi),
        .phase     (phase),
        .rx_byte   (rx_byte)
    );

    assign spi_sck = phase ^ cpol;

endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk
    import spi_reg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic                  busy,
    input logic                  finish,
    input logic                  en,
    input logic                  cpol,
    input logic                  done_flag,
    input logic                  wcol_flag,
    input logic                  spi_sck
);

    // R6: disabled data write starts nothing
    p_disabled_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_DATA && !en && !busy) |=> !busy);

    // R7: data write while busy raises the collision flag
    p_collision_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_DATA && en && busy) |=> wcol_flag);

    // R10: status write changes no flag
    p_stat_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_STAT && !busy)
        |=> ($stable(done_flag) && $stable(wcol_flag)));

    // R5: clock holds still while idle
    p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cpol)) |-> $stable(spi_sck));

    // R8: completion flag rises only after the engine finished
    p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(finish));

endmodule

bind spi_reg_master spi_reg_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .busy      (busy),
    .finish    (finish),
    .en        (en),
    .cpol      (cpol),
    .done_flag (done_flag),
    .wcol_flag (wcol_flag),
    .spi_sck   (spi_sck)
);

// File: tb/spi_reg_master_tb_top.sv
module spi_reg_master_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       spi_miso;
    logic       spi_mosi;
    logic       spi_sck;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int sck_chg = 0;

    typedef struct {
        logic [7:0] mosi_exp;
        logic [7:0] slave;
        int         half;
        logic       cpol;
        logic       cpha;
    } xfer_t;

    xfer_t exp_q[$];

    always #5 clk = ~clk;

    spi_reg_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_miso  (spi_miso),
        .spi_mosi  (spi_mosi),
        .spi_sck   (spi_sck),
        .irq       (irq)
    );

    always @(spi_sck) sck_chg++;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    function automatic int half_of(input int r);
        case (r)
            0: return 1;
            1: return 2;
            2: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        bus_read(a, v);
        chk(v === e, tag, int'(v), int'(e));
    endtask

    // driver: set mode, queue the expectation, launch the byte
    task automatic launch(input logic pol, input logic pha, input logic ien,
                          input int r, input logic [7:0] tx, input logic [7:0] sl);
        xfer_t it;
        bus_write(2'd0, {ien, 1'b1, 2'b00, pol, pha, 2'(r)});
        it.mosi_exp = tx; it.slave = sl; it.half = half_of(r);
        it.cpol = pol; it.cpha = pha;
        exp_q.push_back(it);
        @(negedge clk);
        bus_write(2'd2, tx);
    endtask

    // monitor: slave model, compares against queued items
    initial begin
        spi_miso = 1'b0;
        forever begin
            xfer_t it;
            logic [7:0] s_tx, s_rx;
            time t_prev, t_now;
            int bad_gap;
            wait (exp_q.size() > 0);
            it = exp_q[0];
            s_tx = it.slave; s_rx = 8'd0; bad_gap = 0; t_prev = 0;
            if (!it.cpha) spi_miso = s_tx[7];
            for (int e = 1; e <= 16; e++) begin
                logic lead;
                @(spi_sck);
                t_now = $time;
                if (e > 1 && (t_now - t_prev) != time'(it.half * 10)) bad_gap++;
                t_prev = t_now;
                lead = (spi_sck != it.cpol);
                if (!it.cpha) begin
                    if (lead) s_rx = {s_rx[6:0], spi_mosi};
                    else begin s_tx = {s_tx[6:0], 1'b0}; spi_miso = s_tx[7]; end
                end else begin
                    if (lead) begin spi_miso = s_tx[7]; s_tx = {s_tx[6:0], 1'b0}; end
                    else s_rx = {s_rx[6:0], spi_mosi};
                end
            end
            chk(s_rx === it.mosi_exp, "R4 R5 mosi byte at slave", int'(s_rx), int'(it.mosi_exp));
            chk(bad_gap == 0, "R3 half period", bad_gap, 0);
            void'(exp_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        wrap_up();
    end

    initial begin
        logic [7:0] v;
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(spi_sck === 1'b0, "R1 sck", int'(spi_sck), 0);
        chk(irq === 1'b0, "R1 irq", int'(irq), 0);
        expect_reg(2'd0, 8'h00, "R1 control");
        expect_reg(2'd1, 8'h00, "R1 status");
        expect_reg(2'd2, 8'h00, "R1 data");

        // R2 control readback and unused offset
        bus_write(2'd0, 8'hB5);
        expect_reg(2'd0, 8'hB5, "R2 control readback");
        expect_reg(2'd3, 8'h00, "R2 offset 3");
        bus_write(2'd0, 8'h30);
        expect_reg(2'd0, 8'h30, "R2 option bits stored");

        // R6 disabled write ignored
        snap = sck_chg;
        bus_write(2'd2, 8'hA5);
        repeat (100) @(negedge clk);
        chk(sck_chg == snap, "R6 no clock edges", sck_chg - snap, 0);
        expect_reg(2'd1, 8'h00, "R6 status");
        expect_reg(2'd2, 8'h00, "R6 data");

        // R3 R4 R5 R8 R9 four modes, four rates
        for (int m = 0; m < 4; m++) begin
            logic pol, pha, ien;
            logic [7:0] tx, sl;
            pol = m[1]; pha = m[0]; ien = ~m[0];
            case (m)
                0: begin tx = 8'hA5; sl = 8'h3C; end
                1: begin tx = 8'h96; sl = 8'hE1; end
                2: begin tx = 8'h01; sl = 8'h80; end
                default: begin tx = 8'hFE; sl = 8'h7F; end
            endcase
            launch(pol, pha, ien, m, tx, sl);
            repeat (16 * half_of(m) + 8) @(negedge clk);
            chk(spi_sck === pol, "R5 sck rests at idle level", int'(spi_sck), int'(pol));
            chk(irq === ien, "R8 irq with enable", int'(irq), int'(ien));
            expect_reg(2'd1, 8'h80, "R8 completion flag");
            expect_reg(2'd2, sl, "R4 received byte");
            expect_reg(2'd1, 8'h00, "R9 recorded flag cleared");
            chk(irq === 1'b0, "R8 irq dropped", int'(irq), 0);
        end

        // R9 R10 data access without recording clears nothing; status write ignored
        launch(1'b0, 1'b0, 1'b0, 0, 8'h5A, 8'hC3);
        repeat (30) @(negedge clk);
        expect_reg(2'd2, 8'hC3, "R4 received byte");
        expect_reg(2'd1, 8'h80, "R9 unrecorded flag kept");
        bus_write(2'd1, 8'h00);
        expect_reg(2'd1, 8'h80, "R10 status write ignored");
        bus_write(2'd1, 8'hFF);
        expect_reg(2'd1, 8'h80, "R10 status reserved bits zero");
        expect_reg(2'd2, 8'hC3, "R9 data read");
        expect_reg(2'd1, 8'h00, "R9 cleared after sequence");

        // R7 collision
        launch(1'b0, 1'b1, 1'b0, 3, 8'h5A, 8'h69);
        repeat (20) @(negedge clk);
        bus_write(2'd2, 8'h3C);
        repeat (16 * 16 + 8) @(negedge clk);
        expect_reg(2'd1, 8'hC0, "R7 collision and completion");
        expect_reg(2'd2, 8'h69, "R7 transfer not restarted");
        expect_reg(2'd1, 8'h00, "R9 both recorded flags cleared");
        snap = sck_chg;
        repeat (20) @(negedge clk);
        chk(sck_chg == snap, "R7 no second transfer", sck_chg - snap, 0);

        // R11 completion discards an earlier recording
        launch(1'b0, 1'b0, 1'b0, 1, 8'h33, 8'h44);
        repeat (3) @(negedge clk);
        bus_write(2'd2, 8'hFF);
        expect_reg(2'd1, 8'h40, "R7 collision mid transfer");
        repeat (40) @(negedge clk);
        expect_reg(2'd2, 8'h44, "R11 data read after completion");
        expect_reg(2'd1, 8'hC0, "R11 flags survive stale recording");
        expect_reg(2'd2, 8'h44, "R11 clear");
        expect_reg(2'd1, 8'h00, "R11 cleared after fresh recording");

        // R12 reset aborts a transfer
        bus_write(2'd0, 8'h43);
        bus_write(2'd2, 8'h81);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(spi_sck === 1'b0, "R12 sck after reset", int'(spi_sck), 0);
        rst_n = 1'b1;
        snap = sck_chg;
        repeat (300) @(negedge clk);
        chk(sck_chg == snap, "R12 transfer aborted", sck_chg - snap, 0);
        expect_reg(2'd1, 8'h00, "R12 no completion");
        expect_reg(2'd0, 8'h00, "R12 control cleared");

        wrap_up();
    end

endmodule